// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

The walker follows a chain of command packets held in main memory and hands their payload words, one at a time, to a downstream command port. Each packet (node) begins with one header word: the top byte gives how many payload words follow, and the low 24 bits point at the next node. After the header has been fetched, the payload words, which sit directly behind the header in memory, are read and streamed out. The walker then jumps to the next node. A walk ends when the address about to be visited carries the end marker in bit 23.

While it walks, the block adds up a fixed-formula estimate of the bus cycles the chain costs, so that the caller can charge the transfer to its timing budget. A node limit protects against circular chains. Once that many headers have been fetched without reaching the end marker, the walk is abandoned and an error flag is raised. The output stream honours a ready signal, and no payload read is issued while a word is still waiting to be taken.

Top module: `dma_chain_walker`

## Requirements
- R1: A start pulse while idle begins a walk at start_addr masked to its low 24 bits. A start pulse while a walk is in progress is ignored and has no effect on the words, the cost or the end of the current walk.
- R2: A header word is decoded with bits 31:24 as the payload word count and bits 23:0 as the next-node address. A byte address reaches memory as the word index taken from its bits 20:2 (a 2 MB space), so bits 22:21 and 1:0 do not affect which word is read.
- R3: The payload words of a node are read from the word indices that follow the header's, in order, and appear on out_data in that order. The index wraps from 0x7FFFF to 0.
- R4: The walk ends when the address about to be visited has bit 23 set. A start address with bit 23 set ends at once, with no output words and a cost of 0.
- R5: The cost estimate, cleared at start, grows by 10 for every node fetched and by a further 5 + count for a node whose count is nonzero.
- R6: A node with a count of zero produces no output words, and the walk continues at its next-node address.
- R7: While out_valid is high and out_ready is low, out_data holds its value. No payload read is issued while an output word is pending.
- R8: When MAX_NODES headers have been fetched and the next address is not terminal, the walk stops with err high together with done. err is low after a walk that reached the end marker.
- R9: done is a single-cycle pulse that comes only after the last output word has been accepted. busy is high from the cycle after the accepted start until done, and is low while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| start_addr | input | 32 | Byte address of the first node |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | MEM_AW | Word index of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Payload word available |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Consumer accepts the word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| err | output | 1 | Walk abandoned at the node limit |
| cycles | output | CYC_W | Bus cycle estimate of the last walk |

## Verification
The assertions assume that memory answers each request with exactly one mem_rvalid before the next request, and that start is pulsed only when the previous walk has finished, apart from a deliberate pulse during a walk that checks the ignore rule. The bench memory model answers every request one cycle later and returns data only then. The bench drives out_ready either always high or in a fixed one-in-three pattern, so the back-pressure path is exercised without the consumer ever holding ready low forever.

// File: rtl/walker_pkg.sv
package walker_pkg;
   localparam int WORD_W   = 32;
   localparam int CNT_W    = 8;
   localparam int PTR_W    = 24;
   localparam int END_BIT  = 23;

   typedef enum logic [2:0] {
      S_IDLE, S_CHECK, S_HREQ, S_HWAIT, S_PREQ, S_PWAIT, S_DONE
   } walk_state_e;

   typedef struct packed {
      logic [CNT_W-1:0] count;
      logic [PTR_W-1:0] next;
   } node_hdr_t;
endpackage

// File: rtl/walker_cost.sv
module walker_cost #(
   parameter int CYC_W    = 32,
   parameter int LEN_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add_en,
   input  logic [LEN_W-1:0] len,
   output logic [CYC_W-1:0] total
);
   localparam int NODE_COST  = 10;
   localparam int EXTRA_COST = 5;

   if (CYC_W < LEN_W + 2) begin : g_bad_width
      $error("walker_cost: CYC_W too narrow");
   end

   logic [CYC_W-1:0] inc;
   always_comb begin
      inc = CYC_W'(NODE_COST);
      if (len != '0) inc = inc + CYC_W'(EXTRA_COST) + CYC_W'(len);
   end

   if (SATURATE) begin : g_sat
      logic [CYC_W:0] sum;
      assign sum = {1'b0, total} + {1'b0, inc};
      always_ff @(posedge clk) begin
         if (!rst_n || clr)  total <= '0;
         else if (add_en)    total <= sum[CYC_W] ? '1 : sum[CYC_W-1:0];
      end
      // R5: a saturating total never goes backwards while adding
      a_r5_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
         add_en && !clr |=> total >= $past(total));
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n || clr)  total <= '0;
         else if (add_en)    total <= total + inc;
      end
   end

   // R5: the estimate only moves when a node is charged
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !add_en && !clr |=> $stable(total));
endmodule

// File: rtl/walker_outslot.sv
module walker_outslot #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] push_data,
   output logic         free,
   output logic         valid,
   output logic [W-1:0] data,
   input  logic         ready
);
   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         valid <= 1'b0;
         data  <= '0;
      end else if (push) begin
         valid <= 1'b1;
         data  <= push_data;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end

   assign free = !valid;

   // R7: the slot is only written when empty
   a_r7_push_empty: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !valid);
   // R7: a stalled word stays put
   a_r7_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready && !flush |=> valid && $stable(data));
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
   import walker_pkg::*;
#(
   parameter int MEM_AW    = 19,
   parameter int MAX_NODES = 16,
   parameter int CYC_W     = 32,
   parameter bit SATURATE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [31:0]       start_addr,
   output logic              mem_req,
   output logic [MEM_AW-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              out_valid,
   output logic [31:0]       out_data,
   input  logic              out_ready,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [CYC_W-1:0]  cycles
);
   localparam int IDX_HI = MEM_AW + 1;
   localparam int NODE_W = $clog2(MAX_NODES + 1);

   if (IDX_HI >= END_BIT) begin : g_bad_aw
      $error("dma_chain_walker: MEM_AW overlaps the end marker");
   end
   if (MAX_NODES < 1) begin : g_bad_nodes
      $error("dma_chain_walker: MAX_NODES must be positive");
   end

   walk_state_e       state;
   logic [PTR_W-1:0]  cur_addr;
   logic [PTR_W-1:0]  next_ptr;
   logic [CNT_W-1:0]  remain;
   logic [MEM_AW-1:0] rd_ptr;
   logic [NODE_W-1:0] node_cnt;
   node_hdr_t         hdr;
   logic              slot_free;
   logic              push;
   logic              hdr_take;
   logic              accept;

   assign hdr      = node_hdr_t'(mem_rdata);
   assign accept   = (state == S_IDLE) && start;
   assign hdr_take = (state == S_HWAIT) && mem_rvalid;
   assign push     = (state == S_PWAIT) && mem_rvalid;

   assign mem_req  = (state == S_HREQ) || ((state == S_PREQ) && slot_free);
   assign mem_addr = (state == S_HREQ) ? cur_addr[IDX_HI:2] : rd_ptr;
   assign busy     = (state != S_IDLE) && (state != S_DONE);
   assign done     = (state == S_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         cur_addr <= '0;
         next_ptr <= '0;
         remain   <= '0;
         rd_ptr   <= '0;
         node_cnt <= '0;
         err      <= 1'b0;
      end else begin
         unique case (state)
            S_IDLE: if (start) begin
               cur_addr <= start_addr[PTR_W-1:0];
               node_cnt <= '0;
               err      <= 1'b0;
               state    <= S_CHECK;
            end
            S_CHECK: begin
               if (cur_addr[END_BIT]) begin
                  if (slot_free) state <= S_DONE;
               end else if (node_cnt == NODE_W'(MAX_NODES)) begin
                  if (slot_free) begin
                     err   <= 1'b1;
                     state <= S_DONE;
                  end
               end else begin
                  state <= S_HREQ;
               end
            end
            S_HREQ: state <= S_HWAIT;
            S_HWAIT: if (mem_rvalid) begin
               node_cnt <= node_cnt + NODE_W'(1);
               next_ptr <= hdr.next;
               remain   <= hdr.count;
               rd_ptr   <= cur_addr[IDX_HI:2] + MEM_AW'(1);
               if (hdr.count == '0) begin
                  cur_addr <= hdr.next;
                  state    <= S_CHECK;
               end else begin
                  state    <= S_PREQ;
               end
            end
            S_PREQ: if (slot_free) state <= S_PWAIT;
            S_PWAIT: if (mem_rvalid) begin
               rd_ptr <= rd_ptr + MEM_AW'(1);
               remain <= remain - CNT_W'(1);
               if (remain == CNT_W'(1)) begin
                  cur_addr <= next_ptr;
                  state    <= S_CHECK;
               end else begin
                  state    <= S_PREQ;
               end
            end
            S_DONE: state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   walker_cost #(
      .CYC_W(CYC_W), .LEN_W(CNT_W), .SATURATE(SATURATE)
   ) u_cost (
      .clk(clk), .rst_n(rst_n), .clr(accept), .add_en(hdr_take),
      .len(hdr.count), .total(cycles)
   );

   walker_outslot #(.W(WORD_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .flush(1'b0), .push(push),
      .push_data(mem_rdata), .free(slot_free), .valid(out_valid),
      .data(out_data), .ready(out_ready)
   );

   // R2: one read in flight at a time
   a_r2_single_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   // R9: done is one cycle long and leaves the block idle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);
   // R9: done only once the output has drained
   a_r9_drained: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_valid);
   // R8: the error flag appears together with done
   a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);
   // R7: no payload read while a word waits for the consumer
   a_r7_no_read_full: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && (state == S_PREQ) |-> !out_valid);
endmodule

// File: tb/dma_chain_walker_test.sv
module dma_chain_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_addr = '0;
   logic        mem_req;
   logic [18:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        out_valid;
   logic [31:0] out_data;
   logic        out_ready = 1'b1;
   logic        busy, done, err;
   logic [31:0] cycles;

   int errors = 0;
   int checks = 0;
   int tick = 0;
   int stall_bad = 0;
   int stall_seen = 0;
   bit stall_mode = 1'b0;
   bit hold_pend = 1'b0;
   logic [31:0] hold_d = '0;
   logic [31:0] mem [int unsigned];
   logic [31:0] got [$];

   always #5 clk = ~clk;

   dma_chain_walker uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready), .busy(busy), .done(done), .err(err),
      .cycles(cycles)
   );

   function automatic logic [31:0] rd(input logic [18:0] a);
      if (mem.exists(int'(a))) return mem[int'(a)];
      return 32'hDEAD0000 | 32'(a);
   endfunction

   always @(posedge clk) begin
      mem_rvalid <= rst_n && mem_req;
      mem_rdata  <= rd(mem_addr);
   end

   always @(posedge clk) begin
      if (hold_pend && (!out_valid || out_data != hold_d)) stall_bad++;
      if (out_valid && !out_ready) stall_seen++;
      hold_pend = out_valid && !out_ready;
      hold_d    = out_data;
      if (out_valid && out_ready) got.push_back(out_data);
   end

   always @(negedge clk) begin
      tick++;
      out_ready <= stall_mode ? (tick % 3 == 0) : 1'b1;
      if (tick > 190000) begin
         errors++;
         $display("FAIL watchdog: run hung, act=%0d exp<190000", tick);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic run(input logic [31:0] a, input bit poke);
      got.delete();
      @(negedge clk);
      start = 1'b1; start_addr = a;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         if (poke && i == 3) begin start = 1'b1; start_addr = 32'h0080_0000; end
         if (poke && i == 4) start = 1'b0;
         if (done) break;
         @(negedge clk);
      end
      check(done, "R9 done reached", 32'(done), 32'd1);
      check(!busy, "R9 busy low at done", 32'(busy), 32'd0);
      @(negedge clk);
      check(!done, "R9 done one cycle", 32'(done), 32'd0);
   endtask

   task automatic expect_words(input string req, input logic [31:0] exp [$]);
      check(got.size() == exp.size(), req, 32'(got.size()), 32'(exp.size()));
      foreach (exp[i])
         if (i < got.size()) check(got[i] == exp[i], req, got[i], exp[i]);
   endtask

   task automatic t_reset;
      check(!busy && !done && !err, "R9 reset flags", {29'd0, busy, done, err}, 32'd0);
      check(!out_valid && !mem_req, "R9 reset outputs", {30'd0, out_valid, mem_req}, 32'd0);
      check(cycles == 0, "R5 reset cost", cycles, 32'd0);
   endtask

   task automatic t_basic;
      got.delete();
      @(negedge clk);
      start = 1'b1; start_addr = 32'h0000_0100;
      @(negedge clk);
      start = 1'b0;
      check(busy, "R9 busy after start", 32'(busy), 32'd1);
      for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
      @(negedge clk);
      // R2 R3 R6: words of node 1 then node 3, the empty node adds nothing
      expect_words("R3 R6 basic words", '{32'hA1, 32'hA2, 32'hA3, 32'hC1, 32'hC2});
      check(cycles == 45, "R5 basic cost", cycles, 32'd45);
      check(!err, "R8 no err on clean end", 32'(err), 32'd0);
   endtask

   task automatic t_terminal_start;
      run(32'h0080_0000, 1'b0);
      check(got.size() == 0, "R4 terminal start no words", 32'(got.size()), 32'd0);
      check(cycles == 0, "R4 terminal start cost", cycles, 32'd0);
   endtask

   task automatic t_mask_index;
      run(32'hAB00_0400, 1'b0);
      // R1 mask, R2 pointer 0x6004A3 reads word 0x128
      expect_words("R1 R2 mask and index", '{32'hB1, 32'hC1C1, 32'hC2C2});
      check(cycles == 33, "R5 mask cost", cycles, 32'd33);
   endtask

   task automatic t_stall;
      stall_bad = 0; stall_seen = 0; stall_mode = 1'b1;
      run(32'h0000_0100, 1'b0);
      stall_mode = 1'b0;
      expect_words("R7 stalled words", '{32'hA1, 32'hA2, 32'hA3, 32'hC1, 32'hC2});
      check(stall_seen > 0, "R7 stall exercised", 32'(stall_seen), 32'd1);
      check(stall_bad == 0, "R7 stalled data stable", 32'(stall_bad), 32'd0);
      check(cycles == 45, "R5 cost under stall", cycles, 32'd45);
   endtask

   task automatic t_loop;
      run(32'h0000_1000, 1'b0);
      check(err, "R8 err on circular chain", 32'(err), 32'd1);
      check(got.size() == 16, "R8 words before stop", 32'(got.size()), 32'd16);
      check(cycles == 256, "R8 R5 loop cost", cycles, 32'd256);
   endtask

   task automatic t_wrap;
      run(32'h001F_FFF8, 1'b0);
      expect_words("R3 index wrap", '{32'hE1, 32'hE2, 32'hE3});
      check(cycles == 18, "R5 wrap cost", cycles, 32'd18);
      check(!err, "R8 err cleared by new start", 32'(err), 32'd0);
   endtask

   task automatic t_ignore_start;
      run(32'h0000_0100, 1'b1);
      expect_words("R1 start ignored while busy", '{32'hA1, 32'hA2, 32'hA3, 32'hC1, 32'hC2});
      check(cycles == 45, "R1 cost unaffected", cycles, 32'd45);
   endtask

   initial begin
      mem[32'h40]  = {8'd3, 24'h000200};
      mem[32'h41]  = 32'hA1; mem[32'h42] = 32'hA2; mem[32'h43] = 32'hA3;
      mem[32'h80]  = {8'd0, 24'h000300};
      mem[32'hC0]  = {8'd2, 24'hFFFFFF};
      mem[32'hC1]  = 32'hC1; mem[32'hC2] = 32'hC2;
      mem[32'h100] = {8'd1, 24'h6004A3};
      mem[32'h101] = 32'hB1;
      mem[32'h128] = {8'd2, 24'h800000};
      mem[32'h129] = 32'hC1C1; mem[32'h12A] = 32'hC2C2;
      mem[32'h400] = {8'd1, 24'h001000};
      mem[32'h401] = 32'hD1;
      mem[32'h7FFFE] = {8'd3, 24'h800000};
      mem[32'h7FFFF] = 32'hE1; mem[32'h0] = 32'hE2; mem[32'h1] = 32'hE3;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_terminal_start();
      t_mask_index();
      t_stall();
      t_loop();
      t_wrap();
      t_ignore_start();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule